// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Hashed Set Index

This block caches virtual-to-physical page mappings for a 32-bit virtual address space that is shared by several address spaces, each named by an 8-bit identifier. The storage is organised as 4 ways of 32 sets. A lookup picks one set and compares the tags of all four ways at once. A registered response follows one cycle later. It carries the hit status, the hitting way, the translated physical address and the page attributes.

The set index always comes from virtual address bits 16 to 12, whatever the page size. A configuration bit can fold the low five identifier bits into that field with a bitwise XOR. This spreads processes that use the same virtual addresses over different sets. When the single-address-space configuration bit is set, the plain index is used whatever the hashing bit says, and the identifier no longer takes part in matching.

The fill logic is outside this block. It loads entries through a write port that names the target way, and the write port computes the set with the same index rule as a lookup. A one-cycle flush input clears every valid bit.

Top module: `tlb_hashidx`

## Requirements
- R1: After reset every entry is invalid, and `rsp_valid`, `rsp_hit` and `rsp_multi` are 0.
- R2: With `cfg_hash_en`=0, the set used by a lookup or a write is virtual address bits 16:12.
- R3: With `cfg_hash_en`=1 and `cfg_single_space`=0, the set is VA[16:12] XOR identifier[4:0]. The write port uses the same rule with `wr_asid`, so an entry is found only by a lookup that hashes to the same set.
- R4: With `cfg_single_space`=1, the plain index VA[16:12] is used even when `cfg_hash_en`=1.
- R5: A way matches only if its stored VA[31:17] equals the lookup's. For a 1 KB page (`size`=0), the stored VA[11:10] must also match. For a 4 KB page (`size`=1), VA[11:10] are ignored.
- R6: The identifier must be equal unless the entry's shared bit is 1 or `cfg_single_space`=1.
- R7: The physical address is {ppn[18:0], VA[9:0]} for a 1 KB page and {ppn[18:2], VA[11:0]} for a 4 KB page. Here ppn holds physical address bits 28:10.
- R8: On a hit, `rsp_prot`, `rsp_size`, `rsp_cache`, `rsp_dirty` and `rsp_shared` return the stored fields. On a miss, or when there is no lookup, the way, address and attribute outputs are all 0.
- R9: If two or more ways match, `rsp_multi`=1 and `rsp_way` is the lowest-numbered matching way.
- R10: The response is registered. The outputs in cycle n+1 reflect the lookup presented in cycle n, and they use the contents as they stood before any write in cycle n. `rsp_valid` equals the previous cycle's `lk_valid`.
- R11: `inv_all` clears every valid bit in one cycle and takes priority over a write in the same cycle.
- R12: A write changes only the selected way at the computed set. Its `wr_valid` value becomes the entry's valid bit, so writing 0 removes a single entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_hash_en | input | 1 | Fold identifier[4:0] into the set index |
| cfg_single_space | input | 1 | Single address space: plain index, identifier ignored |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Lookup address-space identifier |
| wr_en | input | 1 | Write an entry |
| wr_way | input | 2 | Target way |
| wr_vpn | input | 22 | Virtual address bits 31:10 of the entry |
| wr_asid | input | 8 | Identifier of the entry |
| wr_valid | input | 1 | Valid bit written |
| wr_ppn | input | 19 | Physical address bits 28:10 |
| wr_prot | input | 2 | Protection field |
| wr_size | input | 1 | 0 = 1 KB page, 1 = 4 KB page |
| wr_cache | input | 1 | Cacheable |
| wr_dirty | input | 1 | Dirty |
| wr_shared | input | 1 | Shared across identifiers |
| inv_all | input | 1 | Clear all valid bits |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Some way matched |
| rsp_multi | output | 1 | More than one way matched |
| rsp_way | output | 2 | Matching way (lowest) |
| rsp_paddr | output | 29 | Physical address |
| rsp_prot | output | 2 | Protection field |
| rsp_size | output | 1 | Page size |
| rsp_cache | output | 1 | Cacheable |
| rsp_dirty | output | 1 | Dirty |
| rsp_shared | output | 1 | Shared |

## Verification
The hardest state to reach from the ports is a multiple match. Two ways of one set must hold tags that one probe matches. With hashing on, the write's identifier must also steer both entries into that set. Random stimulus reaches this case often: virtual page numbers are drawn from two high-half values and four index values, identifiers from three values, and pages of both sizes are mixed. As a result, colliding writes, shared entries, the 4 KB tag wildcard and hash aliasing all happen many times. Directed cases then pin down the exact corners: a lookup in the same cycle as a write, a flush in the same cycle as a write, single-space mode overriding the hashing bit, and removal of one way out of a multiple match.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W    = 32;
  localparam int ASID_W  = 8;
  localparam int IDX_W   = 5;
  localparam int IDX_LSB = 12;
  localparam int SETS    = 1 << IDX_W;
  localparam int HI_W    = VA_W - (IDX_LSB + IDX_W);  // VA[31:17]
  localparam int LO_W    = 2;                         // VA[11:10]
  localparam int PPN_W   = 19;                        // PA[28:10]
  localparam int PA_W    = PPN_W + 10;

  typedef struct packed {
    logic [HI_W-1:0]   vpn_hi;
    logic [LO_W-1:0]   vpn_lo;
    logic [ASID_W-1:0] asid;
  } tag_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       prot;
    logic             size4k;
    logic             cache;
    logic             dirty;
    logic             shared;
  } dat_t;

  function automatic logic [IDX_W-1:0] set_index(
      input logic [IDX_W-1:0] page, input logic [IDX_W-1:0] asid_lo,
      input logic hash_en, input logic single);
    return (hash_en && !single) ? (page ^ asid_lo) : page;
  endfunction

  function automatic logic entry_match(input tag_t st, input logic size4k,
      input logic shared, input tag_t probe, input logic single);
    logic hi_ok, lo_ok, id_ok;
    hi_ok = (st.vpn_hi == probe.vpn_hi);
    lo_ok = size4k || (st.vpn_lo == probe.vpn_lo);
    id_ok = shared || single || (st.asid == probe.asid);
    return hi_ok && lo_ok && id_ok;
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [PPN_W-1:0] ppn,
      input logic size4k, input logic [11:0] off);
    return size4k ? {ppn[PPN_W-1:2], off} : {ppn, off[9:0]};
  endfunction
endpackage

// File: rtl/tlb_index_hash.sv
module tlb_index_hash
  import tlb_pkg::*;
(
  input  logic [IDX_W-1:0] page_bits,
  input  logic [IDX_W-1:0] asid_lo,
  input  logic             hash_en,
  input  logic             single,
  output logic [IDX_W-1:0] set_o
);
  assign set_o = set_index(page_bits, asid_lo, hash_en, single);
endmodule

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
  import tlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_set,
  input  logic             wr_valid,
  input  tag_t             wr_tag,
  input  dat_t             wr_dat,
  input  logic [IDX_W-1:0] rd_set,
  input  tag_t             lk_tag,
  input  logic             single,
  output logic             hit_o,
  output dat_t             dat_o,
  output logic             any_valid_o
);
  logic [SETS-1:0] valid_q;
  tag_t            tag_mem [SETS];
  dat_t            dat_mem [SETS];
  tag_t            rd_tag;

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= '0;
    else if (inv_all) valid_q <= '0;
    else if (wr_en)   valid_q[wr_set] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set] <= wr_tag;
      dat_mem[wr_set] <= wr_dat;
    end
  end

  assign rd_tag      = tag_mem[rd_set];
  assign dat_o       = dat_mem[rd_set];
  assign hit_o       = valid_q[rd_set] &&
                       entry_match(rd_tag, dat_o.size4k, dat_o.shared, lk_tag, single);
  assign any_valid_o = |valid_q;
endmodule

// File: rtl/tlb_hit_select.sv
module tlb_hit_select
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] hits,
  input  dat_t                dats [NUM_WAYS],
  output logic                found,
  output logic                multi,
  output logic [WAY_W-1:0]    sel,
  output dat_t                dat_o
);
  always_comb begin
    int cnt;
    cnt   = 0;
    found = 1'b0;
    sel   = '0;
    dat_o = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hits[w]) begin
        cnt++;
        if (!found) begin
          found = 1'b1;
          sel   = WAY_W'(w);
          dat_o = dats[w];
        end
      end
    end
    multi = (cnt > 1);
  end
endmodule

// File: rtl/tlb_hashidx.sv
module tlb_hashidx
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_hash_en,
  input  logic                  cfg_single_space,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [ASID_W-1:0]     lk_asid,
  input  logic                  wr_en,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [VA_W-1:10]      wr_vpn,
  input  logic [ASID_W-1:0]     wr_asid,
  input  logic                  wr_valid,
  input  logic [PPN_W-1:0]      wr_ppn,
  input  logic [1:0]            wr_prot,
  input  logic                  wr_size,
  input  logic                  wr_cache,
  input  logic                  wr_dirty,
  input  logic                  wr_shared,
  input  logic                  inv_all,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_multi,
  output logic [WAY_W-1:0]      rsp_way,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic [1:0]            rsp_prot,
  output logic                  rsp_size,
  output logic                  rsp_cache,
  output logic                  rsp_dirty,
  output logic                  rsp_shared
);
  // named internal events, observed by the bound checker
  logic [IDX_W-1:0]    lk_set, wr_set;
  logic [NUM_WAYS-1:0] way_hit, way_any;
  logic                any_valid;
  logic                sel_found, sel_multi;
  logic [WAY_W-1:0]    sel_way;
  dat_t                sel_dat;
  dat_t                way_dat [NUM_WAYS];
  tag_t                lk_tag, wr_tag;
  dat_t                wr_dat;
  logic                lk_take;

  tlb_index_hash u_lk_hash (
    .page_bits(lk_vaddr[IDX_LSB+IDX_W-1:IDX_LSB]), .asid_lo(lk_asid[IDX_W-1:0]),
    .hash_en(cfg_hash_en), .single(cfg_single_space), .set_o(lk_set));

  tlb_index_hash u_wr_hash (
    .page_bits(wr_vpn[IDX_LSB+IDX_W-1:IDX_LSB]), .asid_lo(wr_asid[IDX_W-1:0]),
    .hash_en(cfg_hash_en), .single(cfg_single_space), .set_o(wr_set));

  assign lk_tag = '{vpn_hi: lk_vaddr[VA_W-1:IDX_LSB+IDX_W], vpn_lo: lk_vaddr[11:10],
                    asid: lk_asid};
  assign wr_tag = '{vpn_hi: wr_vpn[VA_W-1:IDX_LSB+IDX_W], vpn_lo: wr_vpn[11:10],
                    asid: wr_asid};
  assign wr_dat = '{ppn: wr_ppn, prot: wr_prot, size4k: wr_size, cache: wr_cache,
                    dirty: wr_dirty, shared: wr_shared};

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way_bank u_bank (
      .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
      .wr_en(wr_en && !inv_all && (wr_way == WAY_W'(w))),
      .wr_set(wr_set), .wr_valid(wr_valid), .wr_tag(wr_tag), .wr_dat(wr_dat),
      .rd_set(lk_set), .lk_tag(lk_tag), .single(cfg_single_space),
      .hit_o(way_hit[w]), .dat_o(way_dat[w]), .any_valid_o(way_any[w]));
  end

  assign any_valid = |way_any;

  tlb_hit_select #(.NUM_WAYS(NUM_WAYS)) u_sel (
    .hits(way_hit), .dats(way_dat), .found(sel_found), .multi(sel_multi),
    .sel(sel_way), .dat_o(sel_dat));

  assign lk_take = lk_valid && sel_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_multi  <= 1'b0;
      rsp_way    <= '0;
      rsp_paddr  <= '0;
      rsp_prot   <= '0;
      rsp_size   <= 1'b0;
      rsp_cache  <= 1'b0;
      rsp_dirty  <= 1'b0;
      rsp_shared <= 1'b0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_take;
      rsp_multi  <= lk_valid && sel_multi;
      rsp_way    <= lk_take ? sel_way : '0;
      rsp_paddr  <= lk_take ? phys_addr(sel_dat.ppn, sel_dat.size4k, lk_vaddr[11:0]) : '0;
      rsp_prot   <= lk_take ? sel_dat.prot : '0;
      rsp_size   <= lk_take && sel_dat.size4k;
      rsp_cache  <= lk_take && sel_dat.cache;
      rsp_dirty  <= lk_take && sel_dat.dirty;
      rsp_shared <= lk_take && sel_dat.shared;
    end
  end
endmodule

// File: rtl/tlb_hashidx_chk.sv
module tlb_hashidx_chk
  import tlb_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hash_en,
  input logic             cfg_single_space,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_vaddr,
  input logic [ASID_W-1:0] lk_asid,
  input logic             inv_all,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_multi,
  input logic [WAY_W-1:0] rsp_way,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [1:0]       rsp_prot,
  input logic             rsp_size,
  input logic             rsp_cache,
  input logic             rsp_dirty,
  input logic             rsp_shared,
  input logic [IDX_W-1:0] lk_set,
  input logic             any_valid
);
  p_plain_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hash_en |-> lk_set == lk_vaddr[16:12]);

  p_hashed_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hash_en && !cfg_single_space) |-> lk_set == (lk_vaddr[16:12] ^ lk_asid[4:0]));

  p_single_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_single_space |-> lk_set == lk_vaddr[16:12]);

  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_way == '0 && rsp_paddr == '0 && rsp_prot == '0 &&
                  !rsp_size && !rsp_cache && !rsp_dirty && !rsp_shared));

  p_multi_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);

  p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!rsp_valid && !rsp_hit));

  p_flush_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !any_valid);
endmodule

bind tlb_hashidx tlb_hashidx_chk #(.WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hash_en(cfg_hash_en), .cfg_single_space(cfg_single_space),
  .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .inv_all(inv_all),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_multi(rsp_multi), .rsp_way(rsp_way),
  .rsp_paddr(rsp_paddr), .rsp_prot(rsp_prot), .rsp_size(rsp_size), .rsp_cache(rsp_cache),
  .rsp_dirty(rsp_dirty), .rsp_shared(rsp_shared), .lk_set(lk_set), .any_valid(any_valid));

// File: tb/tb_tlb_hashidx.sv
module tb_tlb_hashidx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_hash_en = 0, cfg_single_space = 0;
  logic lk_valid = 0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic wr_en = 0;
  logic [1:0] wr_way = '0;
  logic [31:10] wr_vpn = '0;
  logic [7:0] wr_asid = '0;
  logic wr_valid = 0;
  logic [18:0] wr_ppn = '0;
  logic [1:0] wr_prot = '0;
  logic wr_size = 0, wr_cache = 0, wr_dirty = 0, wr_shared = 0, inv_all = 0;
  logic rsp_valid, rsp_hit, rsp_multi, rsp_size, rsp_cache, rsp_dirty, rsp_shared;
  logic [1:0] rsp_way, rsp_prot;
  logic [28:0] rsp_paddr;

  tlb_hashidx dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side reference storage
  bit          m_v   [4][32];
  logic [14:0] m_hi  [4][32];
  logic [1:0]  m_lo  [4][32];
  logic [7:0]  m_id  [4][32];
  logic [18:0] m_ppn [4][32];
  logic [1:0]  m_pr  [4][32];
  bit          m_sz [4][32], m_c [4][32], m_d [4][32], m_s [4][32];

  function automatic logic [4:0] b_set(input logic [4:0] page, input logic [7:0] id);
    if (cfg_single_space || !cfg_hash_en) return page;
    return page ^ id[4:0];
  endfunction

  function automatic logic [39:0] b_expect();
    logic [4:0] s;
    int n, first;
    logic [28:0] pa;
    s = b_set(lk_vaddr[16:12], lk_asid);
    n = 0; first = 0;
    for (int w = 3; w >= 0; w--) begin
      if (m_v[w][s] && m_hi[w][s] == lk_vaddr[31:17] &&
          (m_sz[w][s] || m_lo[w][s] == lk_vaddr[11:10]) &&
          (m_s[w][s] || cfg_single_space || m_id[w][s] == lk_asid)) begin
        n++; first = w;
      end
    end
    if (!lk_valid) return 40'd0;
    if (n == 0) return {1'b1, 39'd0};
    pa = m_sz[first][s] ? {m_ppn[first][s][18:2], lk_vaddr[11:0]}
                        : {m_ppn[first][s], lk_vaddr[9:0]};
    return {1'b1, 1'b1, (n > 1), 2'(first), pa, m_pr[first][s],
            m_sz[first][s], m_c[first][s], m_d[first][s], m_s[first][s]};
  endfunction

  function automatic void b_update();
    logic [4:0] s;
    if (inv_all) begin
      for (int w = 0; w < 4; w++) for (int k = 0; k < 32; k++) m_v[w][k] = 0;
    end else if (wr_en) begin
      s = b_set(wr_vpn[16:12], wr_asid);
      m_v[wr_way][s] = wr_valid;   m_hi[wr_way][s] = wr_vpn[31:17];
      m_lo[wr_way][s] = wr_vpn[11:10]; m_id[wr_way][s] = wr_asid;
      m_ppn[wr_way][s] = wr_ppn;   m_pr[wr_way][s] = wr_prot;
      m_sz[wr_way][s] = wr_size;   m_c[wr_way][s] = wr_cache;
      m_d[wr_way][s] = wr_dirty;   m_s[wr_way][s] = wr_shared;
    end
  endfunction

  task automatic cycle(input string req);
    logic [39:0] exp, act;
    exp = b_expect();
    @(posedge clk);
    b_update();
    @(negedge clk);
    act = {rsp_valid, rsp_hit, rsp_multi, rsp_way, rsp_paddr, rsp_prot,
           rsp_size, rsp_cache, rsp_dirty, rsp_shared};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
    lk_valid = 0; wr_en = 0; inv_all = 0;
  endtask

  task automatic put(input logic [1:0] way, input logic [31:0] va, input logic [7:0] id,
                     input logic [18:0] ppn, input logic [1:0] pr, input bit sz,
                     input bit c, input bit d, input bit sh, input bit v);
    wr_en = 1; wr_way = way; wr_vpn = va[31:10]; wr_asid = id; wr_valid = v;
    wr_ppn = ppn; wr_prot = pr; wr_size = sz; wr_cache = c; wr_dirty = d; wr_shared = sh;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] id);
    lk_valid = 1; lk_vaddr = va; lk_asid = id;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, then a lookup into an empty array
    cycle("R1");
    look(32'h1234_5678, 8'h03); cycle("R1");

    // R12 / R2 / R8: 1 KB entry, plain index
    put(2'd1, 32'h1234_5400, 8'h03, 19'h5_A5A5, 2'd2, 0, 1, 0, 0, 1); cycle("R12");
    look(32'h1234_57FF, 8'h03); cycle("R2");
    look(32'h1234_5400, 8'h03); cycle("R8");
    look(32'h1234_5C00, 8'h03); cycle("R5");          // VA[11:10] differs, 1 KB page
    // R5 / R7: 4 KB entry ignores VA[11:10]
    put(2'd2, 32'h0ABC_D000, 8'h03, 19'h7_1234, 2'd1, 1, 0, 1, 0, 1); cycle("R12");
    look(32'h0ABC_DEEF, 8'h03); cycle("R7");
    look(32'h0ABC_D123, 8'h03); cycle("R5");
    // R6: identifier mismatch misses; R4: single space ignores it
    look(32'h1234_5400, 8'h04); cycle("R6");
    cfg_single_space = 1; look(32'h1234_5400, 8'h04); cycle("R4");
    cfg_single_space = 0;
    put(2'd0, 32'h5555_3000, 8'h09, 19'h0_0ABC, 2'd3, 0, 1, 1, 1, 1); cycle("R12");
    look(32'h5555_3000, 8'h4D); cycle("R6");          // shared entry
    // R3: hashed index
    cfg_hash_en = 1;
    put(2'd3, 32'h7777_1000, 8'h05, 19'h1_1111, 2'd0, 0, 0, 0, 0, 1); cycle("R12");
    look(32'h7777_1000, 8'h05); cycle("R3");
    cfg_hash_en = 0; look(32'h7777_1000, 8'h05); cycle("R3");
    // R4: single space overrides hashing on write and lookup
    cfg_hash_en = 1; cfg_single_space = 1;
    put(2'd0, 32'h3333_6000, 8'h11, 19'h2_2222, 2'd1, 0, 1, 0, 0, 1); cycle("R12");
    cfg_hash_en = 0; cfg_single_space = 0;
    look(32'h3333_6000, 8'h11); cycle("R4");
    // R9: multiple match, lowest way reported
    put(2'd2, 32'h4444_8000, 8'h07, 19'h3_0000, 2'd1, 0, 0, 0, 0, 1); cycle("R12");
    put(2'd3, 32'h4444_8000, 8'h07, 19'h3_1111, 2'd2, 0, 1, 0, 0, 1); cycle("R12");
    look(32'h4444_8010, 8'h07); cycle("R9");
    // R12: removing way 2 leaves way 3 as a single hit
    put(2'd2, 32'h4444_8000, 8'h07, 19'h0, 2'd0, 0, 0, 0, 0, 0); cycle("R12");
    look(32'h4444_8010, 8'h07); cycle("R12");
    // R10: lookup in the same cycle as its write sees old contents
    look(32'h6666_9000, 8'h02);
    put(2'd1, 32'h6666_9000, 8'h02, 19'h4_4444, 2'd3, 1, 1, 1, 0, 1); cycle("R10");
    look(32'h6666_9000, 8'h02); cycle("R10");
    // R11: flush wins over a write in the same cycle
    inv_all = 1;
    put(2'd0, 32'h2222_2000, 8'h01, 19'h5_0000, 2'd0, 0, 0, 0, 0, 1); cycle("R11");
    look(32'h2222_2000, 8'h01); cycle("R11");
    look(32'h6666_9000, 8'h02); cycle("R11");

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] va;
      logic [7:0] ids [3];
      ids[0] = 8'h01; ids[1] = 8'h02; ids[2] = 8'h21;
      if ($urandom % 60 == 0) begin
        cfg_hash_en = 1'($urandom); cfg_single_space = ($urandom % 4 == 0);
      end
      va = {($urandom % 2) ? 15'h0123 : 15'h7F00, 3'b000, 2'($urandom), 2'($urandom),
            10'($urandom)};
      if ($urandom % 4 != 0) look(va, ids[$urandom % 3]);
      if ($urandom % 3 == 0) begin
        va = {($urandom % 2) ? 15'h0123 : 15'h7F00, 3'b000, 2'($urandom), 2'($urandom),
              10'($urandom)};
        put(2'($urandom), va, ids[$urandom % 3], 19'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4 == 0),
            ($urandom % 8 != 0));
      end
      if ($urandom % 300 == 0) inv_all = 1;
      if (inv_all) cycle("R11");
      else if (cfg_single_space) cycle("R4");
      else if (cfg_hash_en) cycle("R3");
      else cycle("R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule